// File: doc/BRIEF.md
# SPI Status and Mode-Fault Flag Unit

This block sits next to an SPI shift engine and holds everything the CPU sees about the link's state. It decides pin directions from a master/slave role bit. It watches the slave-select pin for a conflict with the selected role. It latches each received byte and keeps three sticky flags: receive-full, overflow and mode fault.

The flags clear only after the CPU reads them. It must first read the status word while a flag is set. The second access then clears that flag: a data read clears receive-full and overflow, and a control write clears the mode fault. A flag that is set again between those two accesses survives the second access. An overflow never overwrites unread data. The late byte is dropped and the held byte stays readable.

The block assumes the slave-select level is already synchronised to `clk`. Clock generation, shifting, baud selection and interrupt routing belong to neighbouring logic.

Top module: `spi_flag_unit`

## Requirements
- R1: With no mode fault pending, role bit 1 (master) drives `sck_oe` and `mosi_oe` high and `miso_oe` low. Role bit 0 (slave) gives the opposite pattern.
- R2: In slave role with the fault enable at 1, a cycle with `ss_n` high while `xfer_busy` is high sets the mode-fault flag (status bit 2) on the next clock.
- R3: In master role with the fault enable at 1, any cycle with `ss_n` low sets the mode-fault flag on the next clock. In the same clock the role bit is forced to 0, overriding a simultaneous control write.
- R4: While the fault enable is 0, the mode-fault flag cannot become set, whatever `ss_n` and `xfer_busy` do.
- R5: Writing the fault enable to 0 does not clear a set mode-fault flag. The flag clears only on a control write that follows a status read which saw the flag set.
- R6: A receive strobe while receive-full (status bit 0) is clear loads `rx_byte` into `rd_data` and sets receive-full on the next clock.
- R7: A receive strobe while receive-full is set sets overflow (status bit 1). The new byte is discarded and `rd_data` keeps the earlier byte.
- R8: Receive-full clears on a data read that follows a status read which saw it set. A data read with no such status read leaves it set.
- R9: Overflow clears on a data read that follows a status read which saw it set, and that read returns the byte held from before the overflow. An overflow that first appears between the two reads survives the data read.
- R10: A synchronous active-high reset clears all three flags, the role bit, the fault enable and `rd_data`.
- R11: While the mode-fault flag is set, `sck_oe`, `mosi_oe` and `miso_oe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | CPU write strobe for the control register |
| wr_master | input | 1 | Role bit value written (1 master, 0 slave) |
| wr_mfen | input | 1 | Mode-fault enable value written |
| ss_n | input | 1 | Slave-select pin level, synchronised |
| xfer_busy | input | 1 | Shift engine has a transfer in progress |
| rx_done | input | 1 | One-cycle strobe: a byte has been received |
| rx_byte | input | DATA_W | Received byte accompanying `rx_done` |
| stat_rd | input | 1 | CPU read strobe for the status word |
| data_rd | input | 1 | CPU read strobe for the data register |
| master | output | 1 | Current role bit |
| mfen | output | 1 | Current mode-fault enable |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| mosi_oe | output | 1 | Output enable for the master-out pin |
| miso_oe | output | 1 | Output enable for the master-in pin |
| status | output | 3 | Status word: bit0 receive-full, bit1 overflow, bit2 mode fault |
| rd_data | output | DATA_W | Held receive byte |

## Verification
The bench builds the block with the default `DATA_W` of 8. The mode-fault logic depends on only four inputs: role, enable, select level and busy. It is therefore swept over all sixteen combinations from reset, and each fault is then taken through both the failed clear path and the valid clear path. Sixteen computed byte patterns exercise the load path, half of them with a forced overflow. Together they exercise both kinds of data read: one with no preceding status read, and one with it. A dedicated sequence raises an overflow between the status read and the data read. This checks that only the flag seen by the status read is cleared.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    // status word layout: bit0 full, bit1 overflow, bit2 mode fault
    typedef struct packed {
        logic modf;
        logic ovr;
        logic full;
    } flag_t;

    localparam int unsigned STAT_W = $bits(flag_t);

    typedef struct packed {
        logic sck;
        logic mosi;
        logic miso;
    } pin_oe_t;

    // conflict between select pin and role, gated by the enable
    function automatic logic mode_fault(input role_e role, input logic en,
                                        input logic sel_n, input logic busy);
        logic hit;
        if (role == ROLE_MASTER) hit = !sel_n;
        else                     hit = sel_n && busy;
        return en && hit;
    endfunction

endpackage

// File: rtl/spi_pin_dir.sv
module spi_pin_dir
    import spi_flag_pkg::*;
(
    input  role_e   role,
    input  logic    fault,
    output pin_oe_t oe
);
    always_comb begin
        oe = '0;
        if (!fault) begin
            if (role == ROLE_MASTER) begin
                oe.sck  = 1'b1;
                oe.mosi = 1'b1;
            end else begin
                oe.miso = 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_modf_ctrl.sv
module spi_modf_ctrl
    import spi_flag_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ctrl_wr,
    input  logic  wr_master,
    input  logic  wr_mfen,
    input  logic  ss_n,
    input  logic  xfer_busy,
    input  logic  stat_rd,
    output role_e role,
    output logic  mfen,
    output logic  modf
);
    role_e role_q;
    logic  mfen_q;
    logic  modf_q;
    logic  arm_q;
    logic  fault;

    assign fault = mode_fault(role_q, mfen_q, ss_n, xfer_busy);

    always_ff @(posedge clk) begin
        if (rst) begin
            role_q <= ROLE_SLAVE;
            mfen_q <= 1'b0;
            modf_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                role_q <= role_e'(wr_master);
                mfen_q <= wr_mfen;
            end
            if (fault) begin
                modf_q <= 1'b1;
                role_q <= ROLE_SLAVE;
                arm_q  <= 1'b0;
            end else begin
                if (stat_rd && modf_q) arm_q <= 1'b1;
                if (ctrl_wr && arm_q) begin
                    modf_q <= 1'b0;
                    arm_q  <= 1'b0;
                end
            end
        end
    end

    assign role = role_q;
    assign mfen = mfen_q;
    assign modf = modf_q;
endmodule

// File: rtl/spi_rx_flags.sv
module spi_rx_flags #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              stat_rd,
    input  logic              data_rd,
    output logic              full,
    output logic              ovr,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] data_q;
    logic              full_q, ovr_q;
    logic              full_arm, ovr_arm;
    logic              clr_full, clr_ovr, still_full;

    assign clr_full   = data_rd && full_arm;
    assign clr_ovr    = data_rd && ovr_arm;
    assign still_full = full_q && !clr_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q   <= '0;
            full_q   <= 1'b0;
            ovr_q    <= 1'b0;
            full_arm <= 1'b0;
            ovr_arm  <= 1'b0;
        end else begin
            if (stat_rd && full_q) full_arm <= 1'b1;
            if (stat_rd && ovr_q)  ovr_arm  <= 1'b1;
            if (clr_full) begin
                full_q   <= 1'b0;
                full_arm <= 1'b0;
            end
            if (clr_ovr) begin
                ovr_q   <= 1'b0;
                ovr_arm <= 1'b0;
            end
            if (rx_done) begin
                if (still_full) begin
                    ovr_q   <= 1'b1;
                    ovr_arm <= 1'b0;
                end else begin
                    data_q   <= rx_byte;
                    full_q   <= 1'b1;
                    full_arm <= 1'b0;
                end
            end
        end
    end

    assign full = full_q;
    assign ovr  = ovr_q;
    assign data = data_q;
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
    import spi_flag_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              wr_master,
    input  logic              wr_mfen,
    input  logic              ss_n,
    input  logic              xfer_busy,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              stat_rd,
    input  logic              data_rd,
    output logic              master,
    output logic              mfen,
    output logic              sck_oe,
    output logic              mosi_oe,
    output logic              miso_oe,
    output logic [STAT_W-1:0] status,
    output logic [DATA_W-1:0] rd_data
);
    role_e   role;
    flag_t   flags;
    pin_oe_t oe;

    spi_modf_ctrl u_modf (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .wr_master (wr_master),
        .wr_mfen   (wr_mfen),
        .ss_n      (ss_n),
        .xfer_busy (xfer_busy),
        .stat_rd   (stat_rd),
        .role      (role),
        .mfen      (mfen),
        .modf      (flags.modf)
    );

    spi_rx_flags #(.DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .rx_done (rx_done),
        .rx_byte (rx_byte),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .full    (flags.full),
        .ovr     (flags.ovr),
        .data    (rd_data)
    );

    spi_pin_dir u_pins (
        .role  (role),
        .fault (flags.modf),
        .oe    (oe)
    );

    assign master  = (role == ROLE_MASTER);
    assign sck_oe  = oe.sck;
    assign mosi_oe = oe.mosi;
    assign miso_oe = oe.miso;
    assign status  = flags;
endmodule

// File: rtl/spi_flag_unit_chk.sv
module spi_flag_unit_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ctrl_wr,
    input logic              ss_n,
    input logic              xfer_busy,
    input logic              rx_done,
    input logic [DATA_W-1:0] rx_byte,
    input logic              data_rd,
    input logic              master,
    input logic              mfen,
    input logic              sck_oe,
    input logic              mosi_oe,
    input logic              miso_oe,
    input logic [2:0]        status,
    input logic [DATA_W-1:0] rd_data
);
    p_master_pins_r1: assert property (@(posedge clk) disable iff (rst)
        (master && !status[2]) |-> (sck_oe && mosi_oe && !miso_oe));
    p_slave_pins_r1: assert property (@(posedge clk) disable iff (rst)
        (!master && !status[2]) |-> (!sck_oe && !mosi_oe && miso_oe));
    p_slave_fault_r2: assert property (@(posedge clk) disable iff (rst)
        (mfen && !master && ss_n && xfer_busy) |=> status[2]);
    p_master_fault_r3: assert property (@(posedge clk) disable iff (rst)
        (mfen && master && !ss_n) |=> (status[2] && !master));
    p_gate_off_r4: assert property (@(posedge clk) disable iff (rst)
        (!mfen && !status[2]) |=> !status[2]);
    p_modf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (status[2] && !ctrl_wr) |=> status[2]);
    p_load_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !status[0]) |=> (status[0] && rd_data == $past(rx_byte)));
    p_no_overwrite_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_done && status[0] && !data_rd) |=> (status[1] && $stable(rd_data)));
    p_full_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(status[0]) |-> $past(data_rd));
    p_ovr_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(status[1]) |-> $past(data_rd));
    p_pins_off_r11: assert property (@(posedge clk) disable iff (rst)
        status[2] |-> (!sck_oe && !mosi_oe && !miso_oe));
endmodule

bind spi_flag_unit spi_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (ctrl_wr),
    .ss_n      (ss_n),
    .xfer_busy (xfer_busy),
    .rx_done   (rx_done),
    .rx_byte   (rx_byte),
    .data_rd   (data_rd),
    .master    (master),
    .mfen      (mfen),
    .sck_oe    (sck_oe),
    .mosi_oe   (mosi_oe),
    .miso_oe   (miso_oe),
    .status    (status),
    .rd_data   (rd_data)
);

// File: tb/tb_spi_flag_unit.sv
module tb_spi_flag_unit;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b0;
    logic          ctrl_wr = 1'b0, wr_master = 1'b0, wr_mfen = 1'b0;
    logic          ss_n = 1'b1, xfer_busy = 1'b0;
    logic          rx_done = 1'b0;
    logic [DW-1:0] rx_byte = '0;
    logic          stat_rd = 1'b0, data_rd = 1'b0;
    logic          master, mfen, sck_oe, mosi_oe, miso_oe;
    logic [2:0]    status;
    logic [DW-1:0] rd_data;

    int n_chk = 0;
    int n_err = 0;

    spi_flag_unit #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .wr_master(wr_master),
        .wr_mfen(wr_mfen), .ss_n(ss_n), .xfer_busy(xfer_busy),
        .rx_done(rx_done), .rx_byte(rx_byte), .stat_rd(stat_rd),
        .data_rd(data_rd), .master(master), .mfen(mfen), .sck_oe(sck_oe),
        .mosi_oe(mosi_oe), .miso_oe(miso_oe), .status(status),
        .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_reset();
        ss_n = 1'b1; xfer_busy = 1'b0;
        rst = 1'b1; cyc(); cyc(); rst = 1'b0;
    endtask

    task automatic wr_ctrl(input logic m, input logic e);
        ctrl_wr = 1'b1; wr_master = m; wr_mfen = e;
        cyc(); ctrl_wr = 1'b0;
    endtask

    task automatic stat_read();
        stat_rd = 1'b1; cyc(); stat_rd = 1'b0;
    endtask

    task automatic data_read(output logic [DW-1:0] v);
        v = rd_data;
        data_rd = 1'b1; cyc(); data_rd = 1'b0;
    endtask

    task automatic rx(input logic [DW-1:0] b);
        rx_done = 1'b1; rx_byte = b; cyc(); rx_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        cyc();
        do_reset();
        // R10: reset state
        chk("R10 status", 32'(status), 32'h0);
        chk("R10 rd_data", 32'(rd_data), 32'h0);
        chk("R10 role/enable", 32'({master, mfen}), 32'h0);
        chk("R10 pins", 32'({sck_oe, mosi_oe, miso_oe}), 32'b001);

        // sweep role, enable, select level, busy
        for (int i = 0; i < 16; i++) begin
            logic m, e, s, b, exp_f;
            m = i[3]; e = i[2]; s = i[1]; b = i[0];
            exp_f = e && (m ? !s : (s && b));
            do_reset();
            wr_ctrl(m, e);
            chk("R1 pins after write", 32'({sck_oe, mosi_oe, miso_oe}),
                32'({m, m, !m}));
            ss_n = s; xfer_busy = b;
            cyc();
            ss_n = 1'b1; xfer_busy = 1'b0;
            chk(m ? "R3 master fault" : (e ? "R2 slave fault" : "R4 gated"),
                32'(status[2]), 32'(exp_f));
            chk("R3 role forced", 32'(master), 32'(m && !exp_f));
            if (exp_f)
                chk("R11 pins off", 32'({sck_oe, mosi_oe, miso_oe}), 32'h0);
            else
                chk("R1 pins", 32'({sck_oe, mosi_oe, miso_oe}),
                    32'({m, m, !m}));
            if (exp_f) begin
                wr_ctrl(1'b0, 1'b0);
                chk("R5 enable off keeps flag", 32'(status[2]), 32'h1);
                stat_read();
                wr_ctrl(1'b0, 1'b0);
                chk("R5 cleared by sequence", 32'(status[2]), 32'h0);
                ss_n = 1'b1; xfer_busy = 1'b1;
                cyc();
                ss_n = 1'b1; xfer_busy = 1'b0;
                chk("R4 no set while disabled", 32'(status[2]), 32'h0);
                chk("R1 slave pins after clear",
                    32'({sck_oe, mosi_oe, miso_oe}), 32'b001);
            end
        end

        // receive path sweep
        do_reset();
        for (int k = 0; k < 16; k++) begin
            logic [DW-1:0] pat;
            pat = DW'((k * 53 + 17) % 256);
            rx(pat);
            chk("R6 full", 32'(status[0]), 32'h1);
            chk("R6 data", 32'(rd_data), 32'(pat));
            if (k % 2 == 1) begin
                rx(~pat);
                chk("R7 overflow", 32'(status[1]), 32'h1);
                chk("R7 data kept", 32'(rd_data), 32'(pat));
            end
            data_read(v);
            chk("R8 bare data read keeps full", 32'(status[0]), 32'h1);
            stat_read();
            data_read(v);
            chk(k % 2 == 1 ? "R9 read value" : "R8 read value",
                32'(v), 32'(pat));
            chk(k % 2 == 1 ? "R9 flags cleared" : "R8 full cleared",
                32'(status[1:0]), 32'h0);
        end

        // overflow arriving between the two reads
        rx(8'h11);
        stat_read();
        rx(8'h22);
        chk("R7 late overflow", 32'(status[1:0]), 32'b11);
        data_read(v);
        chk("R9 held byte", 32'(v), 32'h11);
        chk("R9 new overflow survives", 32'(status[1:0]), 32'b10);
        stat_read();
        data_read(v);
        chk("R9 overflow cleared", 32'(status[1:0]), 32'b00);
        rx(8'h33);
        chk("R6 reload", 32'({status[0], rd_data}), 32'({1'b1, 8'h33}));

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule